// File: doc/BRIEF.md
# Memory Card Transfer State Controller

This block is the card-side controller that sequences block reads and block writes in a removable memory card. It receives commands that a framing stage has already decoded, as a strobe with a 6-bit opcode and a 32-bit argument. It also receives handshakes from the data path and from the storage array. From these it tracks which of six states the card is in. It checks read arguments against capacity and block geometry, counts blocks preset by a block-count command, and holds up to two written blocks while the array programs them. It drives the busy level on DAT0 and keeps sticky error flags for the next response.

The framing stage pulses `rsp_sent_i` when a response has gone out, and this clears the flags. The data path pulses `blk_done_i` once for each block sent or received, with `crc_ok_i` valid for written blocks. It pulses `rd_err_i` when a read goes wrong. The array pulses `prog_done_i` each time it commits one buffered job.

Top module: `mmc_xfer_ctrl`

## Requirements
- R1: After reset the state is Standby (code 0), all five error flags are 0 and DAT0 is released (`dat0_low_o`=0). State codes: Standby 0, Transfer 1, Data-send 2, Receive 3, Programming 4, Disconnect 5.
- R2: Opcode 7 moves Standby to Transfer when argument bits 31:16 equal the card address, and is ignored without error in Standby when they do not. In Transfer, opcode 7 with a different address returns the card to Standby.
- R3: A read (opcode 17 or 18) in Transfer whose byte address is at or beyond the capacity is refused. The card stays in Transfer and sets flag bit 0.
- R4: A read in Transfer is refused and the card stays in Transfer when the block length set by opcode 16 is 0 or above the maximum read length (flag bit 1). It is also refused when the address offset within a physical block plus the length exceeds the physical block size (flag bit 2). Every flag whose condition holds is set.
- R5: An accepted opcode 17 enters Data-send and returns to Transfer after one block. An opcode 18 following a nonzero count from opcode 23 returns after that many blocks.
- R6: Opcode 23 with argument 0 is accepted. The next opcode 18 then stays in Data-send through any number of blocks until opcode 12.
- R7: After `rd_err_i` in Data-send, further block strobes have no effect and the card stays in Data-send. Opcode 12 then returns it to Transfer and sets flag bit 4.
- R8: A write (opcode 24, or 25) enters Receive. A good-CRC final block moves the card to Programming. A bad CRC sets flag bit 4 and drops the block, and the card goes to Transfer when nothing is buffered. Opcode 12 in Receive goes to Programming if any block is buffered, otherwise to Transfer.
- R9: Up to two written blocks are held. Blocks are still received while earlier ones program. For buffered writes DAT0 is low exactly when both slots are full in Receive or Programming. Programming returns to Transfer when the last slot is released by `prog_done_i`.
- R10: In Programming, reads (17, 18) and parameter commands (16, 23) are refused with flag bit 3 set.
- R11: Opcode 7 with a foreign address in Programming moves to Disconnect and releases DAT0. Opcode 7 with the own address returns to Programming with busy restored. If the work drains while the card is in Disconnect, it goes to Standby.
- R12: Register writes (26, 27) and erase (38) are unbuffered. While one of them programs, DAT0 is low and every data or parameter command is refused with flag bit 3.
- R13: Flags stay set until `rsp_sent_i` and are cleared by it.
- R14: An opcode not legal in the current state (e.g. 12 in Transfer, any opcode but 7 in Standby, an unknown opcode) sets flag bit 3 and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Decoded command strobe |
| cmd_op_i | input | 6 | Command opcode |
| cmd_arg_i | input | 32 | Command argument |
| blk_done_i | input | 1 | One data block sent or received |
| crc_ok_i | input | 1 | CRC of received block good (with blk_done_i) |
| rd_err_i | input | 1 | Read error from data path |
| prog_done_i | input | 1 | Array finished one buffered job |
| rsp_sent_i | input | 1 | Response sent; clears flags |
| state_o | output | 3 | Current state code |
| err_flags_o | output | 5 | Sticky flags: 0 range, 1 length, 2 align, 3 illegal, 4 transfer |
| dat0_low_o | output | 1 | Hold DAT0 low (busy) |

## Verification
Reads are driven with addresses at the capacity edge, with zero, oversized and straddling lengths, and with an exactly fitting offset. This separates the three rejection flags from one another and from acceptance. Multi-block reads are run with a preset count, a zero count and an injected error, which separates counted, open-ended and halted termination. Writes are driven with one and then two outstanding blocks, with a bad CRC, with early stops on an empty and a loaded buffer, and with unbuffered erase and register writes. Deselect and reselect during each kind of programming show when busy is released and when it is restored.

// File: rtl/mmc_xfer_pkg.sv
package mmc_xfer_pkg;
  typedef enum logic [2:0] {
    ST_STBY = 3'd0,
    ST_TRAN = 3'd1,
    ST_SEND = 3'd2,
    ST_RECV = 3'd3,
    ST_PROG = 3'd4,
    ST_DISC = 3'd5
  } xfer_state_t;

  localparam logic [5:0] OP_SEL    = 6'd7;
  localparam logic [5:0] OP_STOP   = 6'd12;
  localparam logic [5:0] OP_BLKLEN = 6'd16;
  localparam logic [5:0] OP_RD1    = 6'd17;
  localparam logic [5:0] OP_RDN    = 6'd18;
  localparam logic [5:0] OP_BLKCNT = 6'd23;
  localparam logic [5:0] OP_WR1    = 6'd24;
  localparam logic [5:0] OP_WRN    = 6'd25;
  localparam logic [5:0] OP_WRID   = 6'd26;
  localparam logic [5:0] OP_WRCFG  = 6'd27;
  localparam logic [5:0] OP_ERASE  = 6'd38;

  localparam int NFLAG     = 5;
  localparam int F_RANGE   = 0;
  localparam int F_LEN     = 1;
  localparam int F_ALIGN   = 2;
  localparam int F_ILLEGAL = 3;
  localparam int F_XFER    = 4;
endpackage

// File: rtl/mmc_rd_check.sv
module mmc_rd_check #(
  parameter logic [31:0] CAP_BYTES = 32'h0010_0000,
  parameter int          PHYS_BLK  = 512,
  parameter int          MAX_LEN   = 512
) (
  input  logic [31:0] addr_i,
  input  logic [31:0] len_i,
  output logic        range_err_o,
  output logic        len_err_o,
  output logic        align_err_o
);
  localparam int OFS_W = $clog2(PHYS_BLK);

  logic [32:0] span;

  assign span        = {1'b0, len_i} + 33'(addr_i[OFS_W-1:0]);
  assign range_err_o = addr_i >= CAP_BYTES;
  assign len_err_o   = (len_i == '0) || (len_i > 32'(MAX_LEN));
  assign align_err_o = span > 33'(PHYS_BLK);
endmodule

// File: rtl/mmc_wbuf.sv
module mmc_wbuf #(
  parameter int SLOTS = 2,
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          full_o
);
  logic [CW-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + CW'(push_i) - CW'(pop_i);
  assign cnt_o     = cnt_q;
  assign full_o    = cnt_q == CW'(SLOTS);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt_o;

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && !pop_i && full_o));
  a_r9_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pop_i && cnt_q == '0));
endmodule

// File: rtl/mmc_xfer_ctrl.sv
module mmc_xfer_ctrl
  import mmc_xfer_pkg::*;
#(
  parameter logic [15:0] CARD_ADDR  = 16'h1234,
  parameter logic [31:0] CAP_BYTES  = 32'h0010_0000,
  parameter int          PHYS_BLK   = 512,
  parameter int          MAX_RD_LEN = 512,
  parameter int          WBUF_SLOTS = 2,
  parameter int          CNT_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [5:0]       cmd_op_i,
  input  logic [31:0]      cmd_arg_i,
  input  logic             blk_done_i,
  input  logic             crc_ok_i,
  input  logic             rd_err_i,
  input  logic             prog_done_i,
  input  logic             rsp_sent_i,
  output logic [2:0]       state_o,
  output logic [NFLAG-1:0] err_flags_o,
  output logic             dat0_low_o
);
  localparam int CW = $clog2(WBUF_SLOTS + 1);

  xfer_state_t      st_q, st_d;
  logic [NFLAG-1:0] flg_q, flg_set;
  logic [31:0]      len_q, len_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, rem_q, rem_d, rem_init;
  logic             cnt_set_q, cnt_set_d, open_q, open_d, open_init;
  logic             halt_q, halt_d, unbuf_q, unbuf_d;
  logic             push, pop, wb_full, multi, sel, is_rd, is_wr;
  logic [CW-1:0]    wb_cnt, wb_nxt;
  logic             e_range, e_len, e_align;

  mmc_rd_check #(.CAP_BYTES(CAP_BYTES), .PHYS_BLK(PHYS_BLK), .MAX_LEN(MAX_RD_LEN)) u_chk (
    .addr_i(cmd_arg_i), .len_i(len_q),
    .range_err_o(e_range), .len_err_o(e_len), .align_err_o(e_align));

  mmc_wbuf #(.SLOTS(WBUF_SLOTS)) u_wbuf (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop),
    .cnt_o(wb_cnt), .cnt_nxt_o(wb_nxt), .full_o(wb_full));

  assign sel       = cmd_arg_i[31:16] == CARD_ADDR;
  assign is_rd     = cmd_op_i == OP_RD1 || cmd_op_i == OP_RDN;
  assign is_wr     = cmd_op_i == OP_WR1 || cmd_op_i == OP_WRN;
  assign multi     = cmd_op_i == OP_RDN || cmd_op_i == OP_WRN;
  assign rem_init  = multi ? cnt_q : CNT_W'(1);
  assign open_init = multi && !(cnt_set_q && cnt_q != '0);
  assign pop       = prog_done_i && wb_cnt != '0;

  always_comb begin
    st_d = st_q; len_d = len_q; cnt_d = cnt_q; cnt_set_d = cnt_set_q;
    rem_d = rem_q; open_d = open_q; halt_d = halt_q; unbuf_d = unbuf_q;
    flg_set = '0; push = 1'b0;
    unique case (st_q)
      ST_STBY:
        if (cmd_valid_i) begin
          if (cmd_op_i != OP_SEL) flg_set[F_ILLEGAL] = 1'b1;
          else if (sel)           st_d = ST_TRAN;
        end
      ST_TRAN:
        if (cmd_valid_i) begin
          if (cmd_op_i == OP_SEL) begin
            if (!sel) st_d = ST_STBY;
          end else if (cmd_op_i == OP_BLKLEN) len_d = cmd_arg_i;
          else if (cmd_op_i == OP_BLKCNT) begin
            cnt_d = cmd_arg_i[CNT_W-1:0]; cnt_set_d = 1'b1;
          end else if (is_rd) begin
            flg_set[F_RANGE] = e_range;
            flg_set[F_LEN]   = e_len;
            flg_set[F_ALIGN] = e_align;
            if (!(e_range || e_len || e_align)) begin
              st_d = ST_SEND; rem_d = rem_init; open_d = open_init;
              cnt_set_d = 1'b0; halt_d = 1'b0;
            end
          end else if (is_wr) begin
            st_d = ST_RECV; rem_d = rem_init; open_d = open_init;
            cnt_set_d = 1'b0; unbuf_d = 1'b0;
          end else if (cmd_op_i == OP_WRID || cmd_op_i == OP_WRCFG) begin
            st_d = ST_RECV; rem_d = CNT_W'(1); open_d = 1'b0;
            cnt_set_d = 1'b0; unbuf_d = 1'b1;
          end else if (cmd_op_i == OP_ERASE) begin
            st_d = ST_PROG; push = 1'b1; unbuf_d = 1'b1;
          end else flg_set[F_ILLEGAL] = 1'b1;
        end
      ST_SEND: begin
        if (rd_err_i) halt_d = 1'b1;
        if (cmd_valid_i) begin
          if (cmd_op_i == OP_STOP) begin
            st_d = ST_TRAN; flg_set[F_XFER] = halt_q || rd_err_i;
          end else flg_set[F_ILLEGAL] = 1'b1;
        end else if (blk_done_i && !halt_q && !rd_err_i && !open_q) begin
          if (rem_q == CNT_W'(1)) st_d = ST_TRAN;
          else                    rem_d = rem_q - 1'b1;
        end
      end
      ST_RECV:
        if (cmd_valid_i) begin
          if (cmd_op_i == OP_STOP) st_d = (wb_nxt != '0) ? ST_PROG : ST_TRAN;
          else flg_set[F_ILLEGAL] = 1'b1;
        end else if (blk_done_i) begin
          if (!crc_ok_i) begin
            flg_set[F_XFER] = 1'b1;
            st_d = (wb_nxt != '0) ? ST_PROG : ST_TRAN;
          end else if (!wb_full || pop) begin
            push = 1'b1;
            if (!open_q && rem_q == CNT_W'(1)) st_d = ST_PROG;
            else if (!open_q)                  rem_d = rem_q - 1'b1;
          end
        end
      ST_PROG: begin
        if (wb_nxt == '0) begin st_d = ST_TRAN; unbuf_d = 1'b0; end
        if (cmd_valid_i) begin
          if (cmd_op_i == OP_SEL) begin
            if (!sel) st_d = (wb_nxt == '0) ? ST_STBY : ST_DISC;
          end else if (is_wr && !unbuf_q) begin
            st_d = ST_RECV; rem_d = rem_init; open_d = open_init; cnt_set_d = 1'b0;
          end else flg_set[F_ILLEGAL] = 1'b1;
        end
      end
      ST_DISC: begin
        if (wb_nxt == '0) begin st_d = ST_STBY; unbuf_d = 1'b0; end
        if (cmd_valid_i) begin
          if (cmd_op_i != OP_SEL) flg_set[F_ILLEGAL] = 1'b1;
          else if (sel)           st_d = (wb_nxt == '0) ? ST_TRAN : ST_PROG;
        end
      end
      default: st_d = ST_STBY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q <= ST_STBY; flg_q <= '0; len_q <= 32'(PHYS_BLK);
      cnt_q <= '0; cnt_set_q <= 1'b0; rem_q <= '0; open_q <= 1'b0;
      halt_q <= 1'b0; unbuf_q <= 1'b0;
    end else begin
      st_q <= st_d; flg_q <= (rsp_sent_i ? '0 : flg_q) | flg_set; len_q <= len_d;
      cnt_q <= cnt_d; cnt_set_q <= cnt_set_d; rem_q <= rem_d; open_q <= open_d;
      halt_q <= halt_d; unbuf_q <= unbuf_d;
    end

  assign state_o     = st_q;
  assign err_flags_o = flg_q;
  assign dat0_low_o  = (st_q == ST_PROG && unbuf_q) ||
                       ((st_q == ST_PROG || st_q == ST_RECV) && wb_full);

  a_r3_range_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && st_q == ST_TRAN && is_rd && cmd_arg_i >= CAP_BYTES
    |=> state_o == 3'd1 && err_flags_o[F_RANGE]);
  a_r10_no_read_in_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && st_q == ST_PROG && is_rd |=> err_flags_o[F_ILLEGAL]);
  a_r11_disc_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd5 |-> !dat0_low_o);
  a_r12_erase_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && st_q == ST_TRAN && cmd_op_i == OP_ERASE |=> dat0_low_o);
  a_r14_stop_in_tran: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && st_q == ST_TRAN && cmd_op_i == OP_STOP
    |=> state_o == 3'd1 && err_flags_o[F_ILLEGAL]);
endmodule

// File: tb/sim_mmc_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_mmc_xfer_ctrl;
  typedef struct {
    string      tag;
    logic [2:0] st;
    logic       d0;
    logic [4:0] fl;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cv = 0, bd = 0, crc = 0, re = 0, pd = 0, rs = 0;
  logic [5:0]  op = '0;
  logic [31:0] arg = '0;
  logic [2:0]  st;
  logic [4:0]  fl;
  logic        d0;
  exp_t        q[$];
  int          n_vec = 0, n_bad = 0;
  bit          done = 0;

  localparam logic [31:0] ME = 32'h1234_0000;

  always #2 clk = ~clk;

  mmc_xfer_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cv), .cmd_op_i(op), .cmd_arg_i(arg),
    .blk_done_i(bd), .crc_ok_i(crc), .rd_err_i(re), .prog_done_i(pd), .rsp_sent_i(rs),
    .state_o(st), .err_flags_o(fl), .dat0_low_o(d0));

  // monitor: pops one expected item per cycle that has one
  always begin
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (st !== e.st || d0 !== e.d0 || fl !== e.fl) begin
        n_bad++;
        $display("FAIL %s actual st=%0d d0=%b fl=%b expected st=%0d d0=%b fl=%b",
                 e.tag, st, d0, fl, e.st, e.d0, e.fl);
      end
    end
  end

  task automatic step(input logic c, input logic [5:0] o, input logic [31:0] a,
                      input logic b, input logic k, input logic r, input logic p,
                      input logic s, input string tag, input logic [2:0] es,
                      input logic ed, input logic [4:0] ef);
    exp_t e;
    @(negedge clk);
    cv = c; op = o; arg = a; bd = b; crc = k; re = r; pd = p; rs = s;
    e.tag = tag; e.st = es; e.d0 = ed; e.fl = ef;
    q.push_back(e);
    @(posedge clk);
    #0.5;
    cv = 0; bd = 0; crc = 0; re = 0; pd = 0; rs = 0;
  endtask

  task automatic cmd(input logic [5:0] o, input logic [31:0] a, input string t,
                     input logic [2:0] es, input logic ed, input logic [4:0] ef);
    step(1, o, a, 0, 0, 0, 0, 0, t, es, ed, ef);
  endtask
  task automatic blk(input logic k, input string t, input logic [2:0] es,
                     input logic ed, input logic [4:0] ef);
    step(0, 0, 0, 1, k, 0, 0, 0, t, es, ed, ef);
  endtask
  task automatic prg(input string t, input logic [2:0] es, input logic ed, input logic [4:0] ef);
    step(0, 0, 0, 0, 0, 0, 1, 0, t, es, ed, ef);
  endtask
  task automatic rsp(input string t, input logic [2:0] es, input logic ed);
    step(0, 0, 0, 0, 0, 0, 0, 1, t, es, ed, 5'h00);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, "R1 reset", 3'd0, 0, 5'h00);
    // R14 / R13: illegal in Standby, sticky, cleared by response
    cmd(6'd17, 0, "R14 read in standby", 3'd0, 0, 5'h08);
    step(0, 0, 0, 0, 0, 0, 0, 0, "R13 sticky", 3'd0, 0, 5'h08);
    rsp("R13 cleared", 3'd0, 0);
    // R2 selection
    cmd(6'd7, 32'hABCD_0000, "R2 foreign select ignored", 3'd0, 0, 5'h00);
    cmd(6'd7, ME, "R2 select", 3'd1, 0, 5'h00);
    // R3 / R4 argument checks
    cmd(6'd17, 32'h0010_0000, "R3 out of range", 3'd1, 0, 5'h01);
    rsp("R13 clear", 3'd1, 0);
    cmd(6'd16, 0, "R4 len zero set", 3'd1, 0, 5'h00);
    cmd(6'd17, 0, "R4 len zero", 3'd1, 0, 5'h02);
    rsp("R13 clear", 3'd1, 0);
    cmd(6'd16, 600, "R4 len big set", 3'd1, 0, 5'h00);
    cmd(6'd17, 0, "R4 len big and straddle", 3'd1, 0, 5'h06);
    rsp("R13 clear", 3'd1, 0);
    cmd(6'd16, 256, "R4 len 256", 3'd1, 0, 5'h00);
    cmd(6'd17, 32'h180, "R4 misalign", 3'd1, 0, 5'h04);
    rsp("R13 clear", 3'd1, 0);
    cmd(6'd17, 32'h100, "R5 fitting offset accepted", 3'd2, 0, 5'h00);
    blk(0, "R5 single read done", 3'd1, 0, 5'h00);
    cmd(6'd16, 512, "R4 len 512", 3'd1, 0, 5'h00);
    // R5 counted multi read
    cmd(6'd23, 2, "R5 preset 2", 3'd1, 0, 5'h00);
    cmd(6'd18, 0, "R5 multi start", 3'd2, 0, 5'h00);
    blk(0, "R5 block 1", 3'd2, 0, 5'h00);
    blk(0, "R5 block 2 ends", 3'd1, 0, 5'h00);
    // R6 zero count open ended
    cmd(6'd23, 0, "R6 preset 0", 3'd1, 0, 5'h00);
    cmd(6'd18, 0, "R6 open start", 3'd2, 0, 5'h00);
    for (int i = 0; i < 3; i++) blk(0, "R6 open block", 3'd2, 0, 5'h00);
    cmd(6'd12, 0, "R6 stop", 3'd1, 0, 5'h00);
    // R14 illegal in Transfer
    cmd(6'd12, 0, "R14 stop in transfer", 3'd1, 0, 5'h08);
    cmd(6'd63, 0, "R14 unknown opcode", 3'd1, 0, 5'h08);
    rsp("R13 clear", 3'd1, 0);
    // R7 read error halts
    cmd(6'd17, 0, "R7 read start", 3'd2, 0, 5'h00);
    step(0, 0, 0, 0, 0, 1, 0, 0, "R7 error not yet reported", 3'd2, 0, 5'h00);
    blk(0, "R7 block ignored", 3'd2, 0, 5'h00);
    cmd(6'd12, 0, "R7 stop reports", 3'd1, 0, 5'h10);
    rsp("R13 clear", 3'd1, 0);
    // R8 / R9 writes
    cmd(6'd24, 0, "R8 write start", 3'd3, 0, 5'h00);
    blk(1, "R8 good block", 3'd4, 0, 5'h00);
    prg("R9 drained", 3'd1, 0, 5'h00);
    cmd(6'd24, 0, "R8 write start", 3'd3, 0, 5'h00);
    blk(0, "R8 bad crc", 3'd1, 0, 5'h10);
    rsp("R13 clear", 3'd1, 0);
    cmd(6'd25, 0, "R9 open write", 3'd3, 0, 5'h00);
    blk(1, "R9 one slot", 3'd3, 0, 5'h00);
    blk(1, "R9 full busy", 3'd3, 1, 5'h00);
    prg("R9 slot freed", 3'd3, 0, 5'h00);
    cmd(6'd12, 0, "R8 stop with buffered", 3'd4, 0, 5'h00);
    cmd(6'd17, 0, "R10 read in prog", 3'd4, 0, 5'h08);
    cmd(6'd23, 4, "R10 count in prog", 3'd4, 0, 5'h08);
    rsp("R13 clear", 3'd4, 0);
    cmd(6'd7, 0, "R11 deselect", 3'd5, 0, 5'h00);
    prg("R11 drain in disconnect", 3'd0, 0, 5'h00);
    cmd(6'd7, ME, "R2 reselect", 3'd1, 0, 5'h00);
    cmd(6'd25, 0, "R8 write start", 3'd3, 0, 5'h00);
    cmd(6'd12, 0, "R8 stop empty", 3'd1, 0, 5'h00);
    // R9 counted write
    cmd(6'd23, 3, "R9 preset 3", 3'd1, 0, 5'h00);
    cmd(6'd25, 0, "R9 counted write", 3'd3, 0, 5'h00);
    blk(1, "R9 blk1", 3'd3, 0, 5'h00);
    blk(1, "R9 blk2 full", 3'd3, 1, 5'h00);
    prg("R9 freed", 3'd3, 0, 5'h00);
    blk(1, "R9 blk3 last", 3'd4, 1, 5'h00);
    prg("R9 one left", 3'd4, 0, 5'h00);
    prg("R9 all done", 3'd1, 0, 5'h00);
    // R12 / R11 unbuffered
    cmd(6'd38, 0, "R12 erase busy", 3'd4, 1, 5'h00);
    cmd(6'd24, 0, "R12 write refused", 3'd4, 1, 5'h08);
    rsp("R13 clear", 3'd4, 1);
    cmd(6'd7, 0, "R11 deselect releases", 3'd5, 0, 5'h00);
    cmd(6'd7, ME, "R11 reselect busy", 3'd4, 1, 5'h00);
    prg("R12 erase done", 3'd1, 0, 5'h00);
    cmd(6'd27, 0, "R12 reg write start", 3'd3, 0, 5'h00);
    blk(1, "R12 reg write busy", 3'd4, 1, 5'h00);
    prg("R12 reg write done", 3'd1, 0, 5'h00);
    cmd(6'd7, 0, "R2 deselect to standby", 3'd0, 0, 5'h00);
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule